// File: doc/BRIEF.md
# Age-Counter Least-Recently-Used Victim Selector

This block keeps the usage order of the lines of one associative set and, on request, names the line that has gone longest without being used. Each line owns a small age counter. An access makes its line the youngest (age zero) and makes every other line one step older. A replace request returns the index of the oldest line, so that the surrounding cache controller knows which line to evict.

Accesses come from two sources. A hit strobe carries the index of a line that has just matched. A fill strobe carries the index of a line that has just been loaded. A fill resets its line's age, which protects freshly loaded data from being evicted at once. When both strobes are high in one cycle, they count as a single access, and the fill index is the one used. Ages stop at their largest value instead of wrapping. Ties are broken toward the lowest line number.

Tag comparison, data storage and miss sequencing belong to the surrounding logic.

Top module: `lru_victim_sel`

## Requirements
- R1: After reset, line i has age NUM_LINES-1-i, `victim_vld_o` is low and `victim_idx_o` is 0, so the first replace request names line 0.
- R2: An access sets the accessed line's age to 0 on the next clock edge.
- R3: On an access, every other line whose age is below the maximum gets one year older. A cycle with no hit and no fill changes no age.
- R4: An age that has reached 2^AGE_W-1 stays there on further accesses to other lines and does not wrap.
- R5: A replace request selects the line with the largest age.
- R6: When several lines share the largest age, the lowest-numbered of them is selected.
- R7: A fill strobe counts as an access to `fill_idx_i`, so a freshly filled line is not chosen as victim while any older line exists.
- R8: When `hit_i` and `fill_i` are both high, only `fill_idx_i` is made youngest. The hit index ages like any other line.
- R9: `victim_vld_o` is high in exactly the cycle after a cycle with `repl_req_i` high. The victim it reports is chosen from the ages held before any access in the request cycle.
- R10: In cycles with no replace request, `victim_idx_o` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hit_i | input | 1 | A line of the set was hit this cycle |
| hit_idx_i | input | IDX_W | Index of the hit line |
| fill_i | input | 1 | A line of the set was loaded this cycle |
| fill_idx_i | input | IDX_W | Index of the loaded line |
| repl_req_i | input | 1 | Request for a victim |
| victim_idx_o | output | IDX_W | Registered index of the chosen victim |
| victim_vld_o | output | 1 | One-cycle strobe: `victim_idx_o` answers the previous request |

## Verification
The following are checked by assertions on every cycle:
- the accessed counter is cleared (R2);
- the other counters step or saturate (R3, R4);
- the filled line is protected (R7);
- the reported victim is a maximum and its index is the lowest among ties (R5, R6);
- the strobe timing is correct and the index holds between requests (R9, R10).

Other behaviours show only in the bench's scenarios, because they appear only as the victims reported after particular sequences. These are:
- the reset ordering;
- fill taking precedence over a simultaneous hit;
- the use of pre-access ages for a same-cycle request;
- the tie that saturation creates.

The bench applies an arithmetic sweep over all strobe and index combinations of a four-line set and predicts each victim from an age model.

// File: rtl/lru_pkg.sv
package lru_pkg;

    // Source of the access applied to the age counters in one cycle
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_HIT  = 2'd1,
        ACC_FILL = 2'd2
    } acc_src_e;

endpackage

// File: rtl/lru_age_bank.sv
module lru_age_bank #(
    parameter int NUM_LINES = 4,
    parameter int AGE_W     = 3,
    localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              acc_vld_i,
    input  logic [IDX_W-1:0]                  acc_idx_i,
    output logic [NUM_LINES-1:0][AGE_W-1:0]   ages_o
);

    localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

    logic [NUM_LINES-1:0][AGE_W-1:0] age_d, age_q;

    always_comb begin
        age_d = age_q;
        if (acc_vld_i) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (acc_idx_i == IDX_W'(i)) begin
                    age_d[i] = '0;
                end else if (age_q[i] != AGE_MAX) begin
                    age_d[i] = age_q[i] + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                age_q[i] <= AGE_W'(NUM_LINES - 1 - i);
            end
        end else begin
            age_q <= age_d;
        end
    end

    assign ages_o = age_q;

    AST_ACC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_vld_i |=> (age_q[$past(acc_idx_i)] == '0)); // R2

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line_chk
        AST_AGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_vld_i && acc_idx_i != IDX_W'(g) && age_q[g] != AGE_MAX)
            |=> (age_q[g] == $past(age_q[g]) + 1'b1)); // R3
        AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !acc_vld_i |=> $stable(age_q[g])); // R3
        AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
            (age_q[g] == AGE_MAX && !(acc_vld_i && acc_idx_i == IDX_W'(g)))
            |=> (age_q[g] == AGE_MAX)); // R4
    end

endmodule

// File: rtl/lru_oldest_pick.sv
module lru_oldest_pick #(
    parameter int NUM_LINES = 4,
    parameter int AGE_W     = 3,
    localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_LINES-1:0][AGE_W-1:0]   ages_i,
    output logic [IDX_W-1:0]                  oldest_o
);

    logic [AGE_W-1:0] best_age;

    // Strict comparison keeps the lowest index among equal ages
    always_comb begin
        oldest_o = '0;
        best_age = ages_i[0];
        for (int i = 1; i < NUM_LINES; i++) begin
            if (ages_i[i] > best_age) begin
                best_age = ages_i[i];
                oldest_o = IDX_W'(i);
            end
        end
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_pick_chk
        AST_PICK_IS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
            ages_i[g] <= ages_i[oldest_o]); // R5
        AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
            (IDX_W'(g) < oldest_o) |-> (ages_i[g] < ages_i[oldest_o])); // R6
    end

endmodule

// File: rtl/lru_victim_sel.sv
module lru_victim_sel #(
    parameter int NUM_LINES = 4,
    parameter int AGE_W     = 3,
    localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  logic [IDX_W-1:0] hit_idx_i,
    input  logic             fill_i,
    input  logic [IDX_W-1:0] fill_idx_i,
    input  logic             repl_req_i,
    output logic [IDX_W-1:0] victim_idx_o,
    output logic             victim_vld_o
);

    import lru_pkg::*;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             vld;
    } vict_t;

    vict_t                           vict_d, vict_q;
    acc_src_e                        acc_src;
    logic                            acc_vld;
    logic [IDX_W-1:0]                acc_idx;
    logic [NUM_LINES-1:0][AGE_W-1:0] ages;
    logic [IDX_W-1:0]                oldest;

    // Access merge: a fill overrides a simultaneous hit
    always_comb begin
        if (fill_i) begin
            acc_src = ACC_FILL;
        end else if (hit_i) begin
            acc_src = ACC_HIT;
        end else begin
            acc_src = ACC_NONE;
        end
        acc_vld = (acc_src != ACC_NONE);
        acc_idx = (acc_src == ACC_FILL) ? fill_idx_i : hit_idx_i;
    end

    lru_age_bank #(
        .NUM_LINES (NUM_LINES),
        .AGE_W     (AGE_W)
    ) u_age_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_vld_i (acc_vld),
        .acc_idx_i (acc_idx),
        .ages_o    (ages)
    );

    lru_oldest_pick #(
        .NUM_LINES (NUM_LINES),
        .AGE_W     (AGE_W)
    ) u_oldest_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .ages_i   (ages),
        .oldest_o (oldest)
    );

    always_comb begin
        vict_d     = vict_q;
        vict_d.vld = repl_req_i;
        if (repl_req_i) begin
            vict_d.idx = oldest;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vict_q <= '0;
        end else begin
            vict_q <= vict_d;
        end
    end

    assign victim_idx_o = vict_q.idx;
    assign victim_vld_o = vict_q.vld;

    AST_VLD_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        repl_req_i |=> victim_vld_o); // R9
    AST_NO_SPURIOUS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        !repl_req_i |=> !victim_vld_o); // R9
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !repl_req_i |=> $stable(victim_idx_o)); // R10
    AST_FILL_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
        fill_i |=> (ages[$past(fill_idx_i)] == '0)); // R7

endmodule

// File: tb/lru_victim_sel_bench.sv
module lru_victim_sel_bench;

    localparam int N     = 4;
    localparam int AW    = 3;
    localparam int IW    = 2;
    localparam int AMAX  = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hit_i = 1'b0;
    logic [IW-1:0] hit_idx_i = '0;
    logic          fill_i = 1'b0;
    logic [IW-1:0] fill_idx_i = '0;
    logic          repl_req_i = 1'b0;
    logic [IW-1:0] victim_idx_o;
    logic          victim_vld_o;

    int n_chk  = 0;
    int n_fail = 0;
    int age_m [N];
    int held_idx = 0;

    always #4 clk = ~clk;

    lru_victim_sel #(.NUM_LINES(N), .AGE_W(AW)) u_lru_victim_sel (
        .clk          (clk),
        .rst_n        (rst_n),
        .hit_i        (hit_i),
        .hit_idx_i    (hit_idx_i),
        .fill_i       (fill_i),
        .fill_idx_i   (fill_idx_i),
        .repl_req_i   (repl_req_i),
        .victim_idx_o (victim_idx_o),
        .victim_vld_o (victim_vld_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int oldest_m();
        int w = 0;
        for (int i = 1; i < N; i++) if (age_m[i] > age_m[w]) w = i;
        return w;
    endfunction

    // One cycle: drive at negedge, model at the edge, compare at next negedge
    task automatic step(input bit h, input int hi, input bit f, input int fi,
                        input bit r, input string req);
        int exp_idx;
        bit acc;
        int ai;
        hit_i = h; hit_idx_i = IW'(hi);
        fill_i = f; fill_idx_i = IW'(fi);
        repl_req_i = r;
        exp_idx = r ? oldest_m() : held_idx;
        acc = h | f;
        ai  = f ? fi : hi;
        if (acc) begin
            for (int i = 0; i < N; i++) begin
                if (i == ai) age_m[i] = 0;
                else if (age_m[i] < AMAX) age_m[i]++;
            end
        end
        @(negedge clk);
        check({req, " vld"}, int'(victim_vld_o), int'(r));
        check({req, " idx"}, int'(victim_idx_o), exp_idx);
        held_idx = exp_idx;
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) age_m[i] = N - 1 - i;
        repeat (3) @(negedge clk);
        check("R1 reset vld", int'(victim_vld_o), 0);
        check("R1 reset idx", int'(victim_idx_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        step(0, 0, 0, 0, 1, "R1 first victim");          // expect 0
        step(1, 0, 0, 0, 1, "R9 pre-access ages");       // still 0
        step(0, 0, 0, 0, 1, "R2 R3 hit ages others");    // expect 1
        step(1, 1, 0, 0, 0, "R10 hold");
        step(0, 0, 1, 1, 1, "R7 fill");
        step(0, 0, 0, 0, 1, "R7 filled line protected");
        step(1, 2, 1, 3, 0, "R8 fill over hit");
        step(0, 0, 0, 0, 1, "R8 victim after merge");
        for (int k = 0; k < 9; k++) step(1, 3, 0, 0, 0, "R4 saturate");
        step(0, 0, 0, 0, 1, "R4 R6 saturated tie");      // expect 0
        step(0, 0, 0, 0, 0, "R10 idle hold");
        step(0, 0, 0, 0, 0, "R3 idle no aging");
        step(0, 0, 0, 0, 1, "R3 idle no aging victim");
        for (int c = 0; c < 3000; c++) begin
            int k = c * 37 + (c >> 3);
            step(k[0], k[2:1], k[3] & k[5], k[7:6], k[4], "R5 R6 sweep");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule